// File: doc/BRIEF.md
# Oscillator start-up delay sequencer

This block keeps the core clock enable low after a reset release or a wake-up from sleep until the oscillator has had time to settle. It runs on the raw oscillator clock. It counts oscillator cycles, and the number it counts is chosen by a 3-bit option code. The code is made of one clock-select bit followed by a 2-bit start-up field.

A wake-up only waits for the oscillator start count. A reset release waits for the same start count, then for a fixed 14 cycles, and then, depending on the code, for 0, 4 or 64 rising edges of a 1 ms tick. The tick comes from a separate slow timebase and is brought into the oscillator domain through a synchroniser.

When the sequence is done, the block raises the clock enable. The enable stays high until a sleep request drops it. A new reset release at any point starts the sequence again.

Top module: `osc_startup_seq`

## Requirements
- R1: While `rst_n` is low, and afterwards until a start is accepted and completed, `clk_en` is 0.
- R2: The start count, in oscillator cycles, is 258 for codes 3'b000 and 3'b001, 1024 for 3'b010, 3'b011 and 3'b100, and 16384 for 3'b101, 3'b110 and 3'b111. Bit 2 of `opt_code` is the clock-select bit and bits 1:0 are the start-up field.
- R3: On a reset start (a `por_release` pulse sampled at edge E0), the start count is followed by exactly 14 more cycles. With no millisecond wait, `clk_en` is high from edge E0+N+14 on, where N is the start count.
- R4: After those 14 cycles, a reset start waits for a number of tick rises: 0 for codes 3'b010 and 3'b101, 4 for 3'b000, 3'b011 and 3'b110, and 64 for 3'b001, 3'b100 and 3'b111. A high level of `ms_tick` first sampled at edge t is counted at edge t+2, and only if the wait had already begun before that edge. `clk_en` rises at the edge that counts the last tick. Rises that come earlier are ignored.
- R5: On a wake start (a `wake_req` sampled at edge E0 while idle), `clk_en` is high from edge E0+N on, with no extra cycles and no tick wait.
- R6: `opt_code` is captured at the start edge. Changing it later has no effect on that sequence's timing.
- R7: A `por_release` pulse in any state restarts a reset sequence, with the code sampled at that edge, and `clk_en` goes low on the next cycle.
- R8: Once high, `clk_en` stays high until `sleep_req` is sampled high. It is then low from the next edge on, and the block is idle.
- R9: `wake_req` is ignored unless the block is idle, and `sleep_req` is ignored unless `clk_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Raw oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| opt_code | input | 3 | Option code {clock select, start-up field[1:0]} |
| ms_tick | input | 1 | 1 ms tick from the slow timebase, asynchronous |
| por_release | input | 1 | Reset-release pulse that starts a reset sequence |
| wake_req | input | 1 | Wake-up request that starts a wake sequence from idle |
| sleep_req | input | 1 | Sleep request that drops the enable |
| clk_en | output | 1 | Core clock enable / ready |

## Verification
The bench runs all eight codes through both the reset path and the wake path, and checks the exact edge at which the enable rises. A block that mixed up the code groups, or that added the 14 cycles or the tick wait on a wake-up, would rise at the wrong edge. The tick runs free with a shortened period, so tick rises that land during the cycle counting test whether early rises leak into the millisecond count, which would make the enable rise too early.

Other cases are also covered:
- The code is changed right after each start, which catches a block that reads it live instead of latching it.
- A reset release in the middle of a count must restart the count from zero.
- Wake and sleep requests in the wrong states must leave both the enable and the timing untouched.

// File: rtl/osc_su_pkg.sv
package osc_su_pkg;

  localparam int unsigned RST_EXTRA_CYC = 14;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_OSC   = 3'd1,
    ST_RCYC  = 3'd2,
    ST_RMS   = 3'd3,
    ST_READY = 3'd4
  } seq_state_e;

  // Oscillator cycles to wait on every start, from the option code.
  function automatic int unsigned start_cycles(input logic [2:0] code);
    case (code)
      3'b000, 3'b001:         return 258;
      3'b010, 3'b011, 3'b100: return 1024;
      default:                return 16384;
    endcase
  endfunction

  // Millisecond ticks added after a reset start, from the option code.
  function automatic int unsigned ms_ticks(input logic [2:0] code);
    case (code)
      3'b010, 3'b101:         return 0;
      3'b000, 3'b011, 3'b110: return 4;
      default:                return 64;
    endcase
  endfunction

endpackage

// File: rtl/osc_su_tick_sync.sv
module osc_su_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_async,
  output logic tick_rise
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= tick_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[LAST];
  end

  assign tick_rise = sync_q[LAST] & ~prev_q;

  // R4
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_rise |=> !tick_rise);

endmodule

// File: rtl/osc_su_count.sv
module osc_su_count #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] target,
  output logic         last
);
  logic [W-1:0] cnt_q;

  assign last = inc && !clr && (cnt_q == target - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr || last) cnt_q <= '0;
    else if (inc)        cnt_q <= cnt_q + W'(1);
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |-> (cnt_q < target));

endmodule

// File: rtl/osc_su_fsm.sv
module osc_su_fsm
  import osc_su_pkg::*;
#(
  parameter int CYC_W = 15,
  parameter int MS_W  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       opt_code,
  input  logic             por_release,
  input  logic             wake_req,
  input  logic             sleep_req,
  input  logic             cyc_last,
  input  logic             ms_last,
  output logic             cnt_clr,
  output logic             cyc_inc,
  output logic             ms_en,
  output logic [CYC_W-1:0] cyc_target,
  output logic [MS_W-1:0]  ms_target,
  output logic             ready
);
  seq_state_e st_q, st_d;
  logic [2:0] code_q, code_d;
  logic       path_rst_q, path_rst_d;
  logic       wake_start;

  assign wake_start = wake_req && (st_q == ST_IDLE) && !por_release;
  assign cnt_clr    = por_release || wake_start;
  assign cyc_inc    = (st_q == ST_OSC) || (st_q == ST_RCYC);
  assign ms_en      = (st_q == ST_RMS);
  assign ready      = (st_q == ST_READY);
  assign cyc_target = (st_q == ST_RCYC) ? CYC_W'(RST_EXTRA_CYC)
                                        : CYC_W'(start_cycles(code_q));
  assign ms_target  = MS_W'(ms_ticks(code_q));

  always_comb begin
    st_d       = st_q;
    code_d     = code_q;
    path_rst_d = path_rst_q;
    if (por_release) begin
      st_d       = ST_OSC;
      code_d     = opt_code;
      path_rst_d = 1'b1;
    end else if (wake_start) begin
      st_d       = ST_OSC;
      code_d     = opt_code;
      path_rst_d = 1'b0;
    end else begin
      case (st_q)
        ST_OSC:   if (cyc_last) st_d = path_rst_q ? ST_RCYC : ST_READY;
        ST_RCYC:  if (cyc_last) st_d = (ms_target == '0) ? ST_READY : ST_RMS;
        ST_RMS:   if (ms_last)  st_d = ST_READY;
        ST_READY: if (sleep_req) st_d = ST_IDLE;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      code_q     <= '0;
      path_rst_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      code_q     <= code_d;
      path_rst_q <= path_rst_d;
    end
  end

  // R3
  osc_to_rcyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OSC && cyc_last && path_rst_q && !por_release) |=> (st_q == ST_RCYC));

  // R5
  wake_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_OSC && cyc_last && !path_rst_q && !por_release) |=> (st_q == ST_READY));

  // R4
  ms_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RMS && ms_last && !por_release) |=> (st_q == ST_READY));

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_release |=> (st_q == ST_OSC && path_rst_q));

  // R6
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_OSC || st_q == ST_RCYC || st_q == ST_RMS) && !por_release) |=> $stable(code_q));

  // R9
  wake_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_READY && wake_req && !sleep_req && !por_release) |=> (st_q == ST_READY));

endmodule

// File: rtl/osc_startup_seq.sv
module osc_startup_seq #(
  parameter int CYC_W       = 15,
  parameter int MS_W        = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_osc,
  input  logic       rst_n,
  input  logic [2:0] opt_code,
  input  logic       ms_tick,
  input  logic       por_release,
  input  logic       wake_req,
  input  logic       sleep_req,
  output logic       clk_en
);
  logic             cnt_clr, cyc_inc, ms_en, cyc_last, ms_last, tick_rise;
  logic [CYC_W-1:0] cyc_target;
  logic [MS_W-1:0]  ms_target;

  osc_su_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk_osc), .rst_n(rst_n), .tick_async(ms_tick), .tick_rise(tick_rise)
  );

  osc_su_count #(.W(CYC_W)) u_cyc (
    .clk(clk_osc), .rst_n(rst_n), .clr(cnt_clr), .inc(cyc_inc),
    .target(cyc_target), .last(cyc_last)
  );

  osc_su_count #(.W(MS_W)) u_ms (
    .clk(clk_osc), .rst_n(rst_n), .clr(cnt_clr), .inc(ms_en && tick_rise),
    .target(ms_target), .last(ms_last)
  );

  osc_su_fsm #(.CYC_W(CYC_W), .MS_W(MS_W)) u_fsm (
    .clk(clk_osc), .rst_n(rst_n), .opt_code(opt_code),
    .por_release(por_release), .wake_req(wake_req), .sleep_req(sleep_req),
    .cyc_last(cyc_last), .ms_last(ms_last), .cnt_clr(cnt_clr),
    .cyc_inc(cyc_inc), .ms_en(ms_en), .cyc_target(cyc_target),
    .ms_target(ms_target), .ready(clk_en)
  );

  // R8
  en_hold_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (clk_en && !sleep_req && !por_release) |=> clk_en);

  // R8
  en_drop_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (clk_en && sleep_req && !por_release) |=> !clk_en);

  // R7
  en_restart_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    por_release |=> !clk_en);

endmodule

// File: tb/test_osc_startup_seq.sv
module test_osc_startup_seq;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_P     = 50;
  localparam int WATCHDOG   = 190000;

  typedef struct {
    int    rdy_cyc;
    string tag;
  } exp_item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] opt_code = 3'b000;
  logic       ms_tick = 1'b0;
  logic       por_release = 1'b0;
  logic       wake_req = 1'b0;
  logic       sleep_req = 1'b0;
  logic       clk_en;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit prev_en = 1'b0;
  exp_item_t sb_q[$];

  osc_startup_seq i_osc_startup_seq (
    .clk_osc(clk), .rst_n(rst_n), .opt_code(opt_code), .ms_tick(ms_tick),
    .por_release(por_release), .wake_req(wake_req), .sleep_req(sleep_req),
    .clk_en(clk_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // free-running shortened tick: high for one cycle when cyc is a multiple of TICK_P
  always @(negedge clk) ms_tick <= (cyc % TICK_P == 0);

  function automatic int n_osc(input int code);
    if (code < 2) return 258;
    if (code < 5) return 1024;
    return 16384;
  endfunction

  function automatic int n_ms(input int code);
    if (code == 2 || code == 5) return 0;
    if (code == 0 || code == 3 || code == 6) return 4;
    return 64;
  endfunction

  // edge at which clk_en must read high, start sampled at edge e0
  function automatic int exp_rdy(input int e0, input int code, input bit rst_path);
    int ems, k1;
    if (!rst_path) return e0 + n_osc(code);
    ems = e0 + n_osc(code) + 14;
    if (n_ms(code) == 0) return ems;
    k1 = ((ems - 2 + TICK_P - 1) / TICK_P) * TICK_P;
    return k1 + (n_ms(code) - 1) * TICK_P + 3;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: each rise of clk_en is matched against the scoreboard head
  always @(negedge clk) begin
    if (rst_n && clk_en && !prev_en) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R1/R7 unexpected clk_en rise", cyc, -1);
      end else begin
        exp_item_t it;
        it = sb_q.pop_front();
        check(cyc == it.rdy_cyc, it.tag, cyc, it.rdy_cyc);
      end
    end
    prev_en <= clk_en;
  end

  task automatic start(input logic [2:0] code, input bit rst_path, input bit push, input string tag);
    exp_item_t it;
    @(negedge clk);
    opt_code = code;
    if (rst_path) por_release = 1'b1; else wake_req = 1'b1;
    if (push) begin
      it.rdy_cyc = exp_rdy(cyc + 1, int'(code), rst_path);
      it.tag = $sformatf("%s code=%03b", tag, code);
      sb_q.push_back(it);
    end
    @(negedge clk);
    por_release = 1'b0;
    wake_req = 1'b0;
    opt_code = ~code;  // R6: later changes must not matter
  endtask

  task automatic wait_sb();
    while (sb_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_sleep();
    @(negedge clk);
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    check(clk_en == 1'b0, "R8 clk_en low after sleep", int'(clk_en), 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", sb_q.size());
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int bad;
    repeat (4) @(negedge clk);
    check(clk_en == 1'b0, "R1 clk_en low in reset", int'(clk_en), 0);
    rst_n = 1'b1;
    bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (clk_en) bad++;
    end
    check(bad == 0, "R1 clk_en low while idle", bad, 0);

    // R7: restart mid-count; only the second start may complete
    start(3'b000, 1'b1, 1'b0, "");
    repeat (100) @(negedge clk);
    start(3'b010, 1'b1, 1'b1, "R7 restart");
    wait_sb();

    // R9: wake_req while ready has no effect
    @(negedge clk);
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (!clk_en) bad++;
    end
    check(bad == 0, "R9 wake ignored while ready, R8 hold", bad, 0);

    // reset path, all codes (R2 R3 R4 R6)
    for (int c = 0; c < 8; c++) begin
      start(3'(c), 1'b1, 1'b1, "R2/R3/R4/R6 reset path");
      wait_sb();
    end

    // wake path, all codes (R2 R5 R6); sleep mid-count is ignored (R9)
    for (int c = 0; c < 8; c++) begin
      do_sleep();
      start(3'(c), 1'b0, 1'b1, "R2/R5/R6/R9 wake path");
      repeat (50) @(negedge clk);
      sleep_req = 1'b1;
      @(negedge clk);
      sleep_req = 1'b0;
      wait_sb();
    end

    // R7: reset release while ready drops the enable at once
    start(3'b101, 1'b1, 1'b1, "R7 restart from ready");
    check(clk_en == 1'b0, "R7 clk_en low after restart", int'(clk_en), 0);
    wait_sb();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule